// File: doc/BRIEF.md
# Multirate Stream Rate Adapter

This block sits between stream ports clocked at the full fabric rate and a processing core whose own stream ports run at a rate RATIO times slower. It does not store frames and it does not resample. It only shapes the handshakes. A free-running phase counter splits time into periods of RATIO cycles, and the first cycle of each period (phase 0) is the only cycle in which a transfer can happen on either side.

On the ingress side, the block raises `s_tready` only in phase 0. This admits at most one upstream sample per period. An accepted sample is registered and handed to the core with a one-cycle strobe. If nothing is offered in phase 0, the core sees no strobe for that period. On the egress side, `m_tvalid` is high only in phase 0, and `m_tdata` carries the core result that was captured at the end of the previous period. If the downstream sink refuses the offer, the same sample is offered again in the next period, and the core result of that period is discarded. With RATIO equal to 1, both sides run every cycle and neither side applies backpressure.

Both gates are small state machines. The ingress machine has states `ING_OPEN` and `ING_SHUT`. It moves to `ING_OPEN` on the last phase of a period and to `ING_SHUT` on any other phase. The egress machine has states `EGR_OFFER`, `EGR_SENT` and `EGR_RETRY`. It goes to `EGR_OFFER` on the last phase. From `EGR_OFFER` it goes to `EGR_SENT` when the sink accepts and to `EGR_RETRY` when the sink refuses. It stays in `EGR_SENT` or `EGR_RETRY` until the next last phase.

Top module: `stream_rate_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the adapter is in phase 0. In that state `s_tready` = 1, `m_tvalid` = 1, `core_in_stb` = 0, `core_in_data` = 0 and `m_tdata` = 0.
- R2: `s_tready` is high in exactly one cycle of every RATIO cycles: the cycles at offsets 0, RATIO, 2·RATIO and so on after reset release.
- R3: `m_tvalid` is high in exactly the same cycles as `s_tready` and is low in all others.
- R4: When `s_tvalid` and `s_tready` are both high at a clock edge, `core_in_stb` is high for the following cycle and `core_in_data` then equals the `s_tdata` accepted at that edge.
- R5: When no transfer happens at an edge, `core_in_stb` is low in the following cycle and `core_in_data` keeps its value. In particular, a period in which `s_tvalid` is low during phase 0 produces no strobe.
- R6: `m_tdata` changes only at the edge that ends a period (phase RATIO-1). It then takes the `core_out_data` present at that edge, provided the offer of the period that is ending was accepted.
- R7: With RATIO = 1, `s_tready` and `m_tvalid` are high on every cycle, every offered sample is taken, and `m_tdata` follows `core_out_data` one cycle later while `m_tready` is high.
- R8: If `m_tready` is low during the phase-0 offer, `m_tdata` is not replaced at the end of that period and the same value is offered again in the next phase 0. `m_tready` never moves or stretches `m_tvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | DATA_W | Upstream sample |
| s_tvalid | input | 1 | Upstream sample valid |
| s_tready | output | 1 | Admit window, high in phase 0 only |
| core_in_data | output | DATA_W | Last sample handed to the core |
| core_in_stb | output | 1 | One-cycle pulse: a new sample is in `core_in_data` |
| core_out_data | input | DATA_W | Result presented by the slow core |
| m_tdata | output | DATA_W | Result offered downstream |
| m_tvalid | output | 1 | Offer strobe, high in phase 0 only |
| m_tready | input | 1 | Downstream acceptance |

## Verification
In phase 0 the adapter does three things in the same cycle: it admits an upstream sample, it makes the downstream offer, and (when RATIO is 1) it closes the period, which loads the next result. The bench drives all three together: upstream valid and downstream ready are both held high, then both toggled at random, then each is held low on its own. It runs one adapter with RATIO 8 and one with RATIO 1 on the same stimulus. A behavioural model keeps a phase count and an accepted flag for each instance and predicts every output on every cycle. A refused phase-0 offer that coincides with a period end is therefore judged on whether the held sample was kept.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic {
        ING_SHUT = 1'b0,
        ING_OPEN = 1'b1
    } ing_state_e;

    typedef enum logic [1:0] {
        EGR_OFFER = 2'd0,
        EGR_SENT  = 2'd1,
        EGR_RETRY = 2'd2
    } egr_state_e;

endpackage

// File: rtl/sra_phase_counter.sv
module sra_phase_counter #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic at_first,
    output logic at_last
);
    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

    generate
        if (RATIO == 1) begin : g_unit
            // every cycle both opens and closes a period
            assign at_first = 1'b1;
            assign at_last  = 1'b1;
        end else begin : g_count
            logic [PH_W-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (phase_q == PH_LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign at_first = (phase_q == '0);
            assign at_last  = (phase_q == PH_LAST);

            AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                phase_q <= PH_LAST); // R2
            AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                !at_last |=> (phase_q == $past(phase_q) + 1'b1)); // R2
        end
    endgenerate

    AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        at_last |=> at_first); // R2

endmodule

// File: rtl/sra_ingress_gate.sv
module sra_ingress_gate
    import sra_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_first,
    input  logic              at_last,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] core_in_data,
    output logic              core_in_stb
);
    ing_state_e state_q, state_d;
    logic       take;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ING_OPEN: state_d = at_last ? ING_OPEN : ING_SHUT;
            ING_SHUT: state_d = at_last ? ING_OPEN : ING_SHUT;
            default:  state_d = ING_SHUT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ING_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        s_tready = 1'b0;
        unique case (state_q)
            ING_OPEN: s_tready = 1'b1;
            ING_SHUT: s_tready = 1'b0;
            default:  s_tready = 1'b0;
        endcase
    end

    assign take = s_tvalid && s_tready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_in_stb  <= 1'b0;
            core_in_data <= '0;
        end else begin
            core_in_stb <= take;
            if (take) begin
                core_in_data <= s_tdata;
            end
        end
    end

    AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready == at_first); // R2
    AST_STB_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready) |=> (core_in_stb && core_in_data == $past(s_tdata))); // R4
    AST_NO_SPURIOUS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tvalid && s_tready) |=> (!core_in_stb && $stable(core_in_data))); // R5

endmodule

// File: rtl/sra_egress_gate.sv
module sra_egress_gate
    import sra_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_first,
    input  logic              at_last,
    input  logic [DATA_W-1:0] core_out_data,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready
);
    egr_state_e state_q, state_d;
    logic       load;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EGR_OFFER: begin
                if (at_last)       state_d = EGR_OFFER;
                else if (m_tready) state_d = EGR_SENT;
                else               state_d = EGR_RETRY;
            end
            EGR_SENT:  state_d = at_last ? EGR_OFFER : EGR_SENT;
            EGR_RETRY: state_d = at_last ? EGR_OFFER : EGR_RETRY;
            default:   state_d = EGR_OFFER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EGR_OFFER;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        m_tvalid = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            EGR_OFFER: begin
                m_tvalid = 1'b1;
                load     = at_last && m_tready;
            end
            EGR_SENT:  load = at_last;
            EGR_RETRY: load = 1'b0;
            default:   load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tdata <= '0;
        end else if (load) begin
            m_tdata <= core_out_data;
        end
    end

    AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid == at_first); // R3
    AST_DATA_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_last |=> $stable(m_tdata)); // R6
    AST_REFUSED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> $stable(m_tdata)); // R8

endmodule

// File: rtl/stream_rate_adapter.sv
module stream_rate_adapter #(
    parameter int RATIO  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] core_in_data,
    output logic              core_in_stb,
    input  logic [DATA_W-1:0] core_out_data,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready
);
    logic at_first;
    logic at_last;

    sra_phase_counter #(.RATIO(RATIO)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .at_first (at_first),
        .at_last  (at_last)
    );

    sra_ingress_gate #(.DATA_W(DATA_W)) u_ingress (
        .clk          (clk),
        .rst_n        (rst_n),
        .at_first     (at_first),
        .at_last      (at_last),
        .s_tdata      (s_tdata),
        .s_tvalid     (s_tvalid),
        .s_tready     (s_tready),
        .core_in_data (core_in_data),
        .core_in_stb  (core_in_stb)
    );

    sra_egress_gate #(.DATA_W(DATA_W)) u_egress (
        .clk           (clk),
        .rst_n         (rst_n),
        .at_first      (at_first),
        .at_last       (at_last),
        .core_out_data (core_out_data),
        .m_tdata       (m_tdata),
        .m_tvalid      (m_tvalid),
        .m_tready      (m_tready)
    );

    AST_SIDES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready == m_tvalid); // R3
    if (RATIO == 1) begin : g_unit_chk
        AST_UNIT_NO_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
            s_tready && m_tvalid); // R7
    end

endmodule

// File: tb/stream_rate_adapter_bench.sv
module stream_rate_adapter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int N_SLOW     = 8;
    localparam int N_UNIT     = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic [DW-1:0] core_out_data = '0;
    logic          m_tready = 1'b0;

    logic          s_tready_o [2];
    logic [DW-1:0] cin_data_o [2];
    logic          cin_stb_o  [2];
    logic [DW-1:0] m_tdata_o  [2];
    logic          m_tvalid_o [2];

    int tests = 0;
    int fails = 0;
    bit run_checks = 1'b0;

    // behavioural model state per instance
    int            ph      [2];
    bit            acc     [2];
    bit            e_stb   [2];
    logic [DW-1:0] e_cdata [2];
    logic [DW-1:0] e_mdata [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_rate_adapter #(.RATIO(N_SLOW), .DATA_W(DW)) u_stream_rate_adapter (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready_o[0]), .core_in_data(cin_data_o[0]), .core_in_stb(cin_stb_o[0]),
        .core_out_data(core_out_data), .m_tdata(m_tdata_o[0]), .m_tvalid(m_tvalid_o[0]),
        .m_tready(m_tready)
    );

    stream_rate_adapter #(.RATIO(N_UNIT), .DATA_W(DW)) u_stream_rate_adapter_unit (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready_o[1]), .core_in_data(cin_data_o[1]), .core_in_stb(cin_stb_o[1]),
        .core_out_data(core_out_data), .m_tdata(m_tdata_o[1]), .m_tvalid(m_tvalid_o[1]),
        .m_tready(m_tready)
    );

    function automatic int ratio_of(int i);
        return (i == 0) ? N_SLOW : N_UNIT;
    endfunction

    task automatic chk(string req, int inst, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst%0d t=%0t actual=%0h expected=%0h", req, inst, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                ph[i] = 0; acc[i] = 1'b0; e_stb[i] = 1'b0;
                e_cdata[i] = '0; e_mdata[i] = '0;
            end else begin
                bit ld;
                ld = 1'b0;
                if (ph[i] == ratio_of(i) - 1)
                    ld = (ph[i] == 0) ? m_tready : acc[i];
                if (ph[i] == 0) acc[i] = m_tready;
                if (ld) e_mdata[i] = core_out_data;
                e_stb[i] = (ph[i] == 0) && s_tvalid;
                if (e_stb[i]) e_cdata[i] = s_tdata;
                ph[i] = (ph[i] + 1) % ratio_of(i);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_checks) begin
            for (int i = 0; i < 2; i++) begin
                chk((i == 0) ? "R2" : "R7", i, 32'(s_tready_o[i]), 32'(ph[i] == 0));
                chk((i == 0) ? "R3" : "R7", i, 32'(m_tvalid_o[i]), 32'(ph[i] == 0));
                chk(e_stb[i] ? "R4" : "R5", i, 32'(cin_stb_o[i]), 32'(e_stb[i]));
                chk("R4", i, 32'(cin_data_o[i]), 32'(e_cdata[i]));
                chk(acc[i] ? "R6" : "R8", i, 32'(m_tdata_o[i]), 32'(e_mdata[i]));
            end
        end
    end

    task automatic drive(int cycles, int vmode, int rmode);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            s_tdata       = DW'($urandom);
            core_out_data = DW'($urandom);
            s_tvalid      = (vmode == 2) ? 1'($urandom) : 1'(vmode);
            m_tready      = (rmode == 2) ? 1'($urandom) : 1'(rmode);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state, before the first active edge
        for (int i = 0; i < 2; i++) begin
            chk("R1", i, 32'(s_tready_o[i]), 32'd1);
            chk("R1", i, 32'(m_tvalid_o[i]), 32'd1);
            chk("R1", i, 32'(cin_stb_o[i]), 32'd0);
            chk("R1", i, 32'(cin_data_o[i]), 32'd0);
            chk("R1", i, 32'(m_tdata_o[i]), 32'd0);
        end
        run_checks = 1'b1;
        drive(48, 1, 1);   // full traffic both sides
        drive(40, 0, 1);   // upstream idle: R5
        drive(96, 2, 2);   // random both
        drive(48, 1, 0);   // sink refuses: R8
        drive(96, 2, 2);
        @(negedge clk);
        finish_run();
    end

endmodule